// File: doc/BRIEF.md
# Activity-Based Sleep/Wake Controller

This block watches a stream of signed three-axis acceleration samples and decides when the sample engine may drop into a low-power configuration. If every axis stays within a programmable threshold for a programmable number of samples, the controller overrides the user's output-rate and mode settings with a fixed slow rate and a low-power mode. When any axis moves beyond the threshold again, it puts the user's settings back and raises a one-clock activity event.

Four small configuration registers sit behind a write port: the threshold, the duration, the user rate and the user mode. The threshold uses the same LSB units as the inertial interrupt threshold, so it is compared directly against the sample magnitudes. A zero threshold switches the feature off. The inactivity timer counts in coarse units: with a duration of N, sleep begins after 8·N+1 quiet samples.

Top module: `act_sleep_ctrl`

## Requirements
- R1: After reset the controller is awake, `asleep` and `wake_evt` are 0, the inactivity count is cleared, and all four configuration registers and both effective outputs are 0.
- R2: While the threshold register holds 0 the controller never sleeps. Writing 0 while asleep returns it to awake with no `wake_evt` pulse, and the effective rate and mode then follow the user registers.
- R3: With a nonzero threshold T and duration D, `asleep` rises at the clock edge that takes the (8·D+1)-th consecutive quiet sample. One quiet sample fewer leaves it awake.
- R4: One clock after `asleep` is high, `eff_rate` equals SLEEP_RATE (default 4'h2, the 10 Hz code) and `eff_mode` equals LP_MODE (default 2'b01, low-power), whatever the user registers hold.
- R5: While awake, a sample with any axis magnitude above T restarts the quiet count from zero. While asleep, such a sample clears `asleep`, and one clock later `eff_rate` and `eff_mode` again equal the user rate and mode registers.
- R6: `wake_evt` is high for exactly one clock, at the same edge where `asleep` falls because of an active sample, and at no other time.
- R7: The quiet count advances only on cycles with `smp_valid` high. Cycles without the strobe change neither the count nor `asleep`.
- R8: The magnitude of each axis is the absolute value of the two's-complement sample, including the most negative value. A magnitude equal to T counts as quiet.
- R9: A write with `cfg_we` high stores the low bits of `cfg_wdata` into the register selected by `cfg_sel`: 0 threshold, 1 duration, 2 user rate (low 4 bits), 3 user mode (low 2 bits). A user rate or mode write made while asleep does not wake the controller and shows on the outputs only after wake-up. While awake, the effective outputs follow the user registers one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one per new sample |
| smp_x | input | 16 | Signed X-axis sample |
| smp_y | input | 16 | Signed Y-axis sample |
| smp_z | input | 16 | Signed Z-axis sample |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| eff_rate | output | 4 | Effective output-rate code |
| eff_mode | output | 2 | Effective mode code |
| asleep | output | 1 | High while the low-power override is active |
| wake_evt | output | 1 | One-clock pulse on each sleep-to-wake transition |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 8-bit threshold and duration fields, and 4-bit rate and 2-bit mode codes. With these widths the longest timeout, 2041 samples at duration 255, fits in the run, so the bench checks both edges of that window alongside duration 0, which sleeps after a single quiet sample. The 16-bit sample width brings the most negative value, -32768, into the stimulus, and the 8-bit threshold allows directed tests at magnitudes exactly equal to the threshold.

// File: rtl/act_pkg.sv
package act_pkg;
  typedef enum logic [1:0] {
    SEL_THR  = 2'd0,
    SEL_DUR  = 2'd1,
    SEL_RATE = 2'd2,
    SEL_MODE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/act_regs.sv
module act_regs
  import act_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int THR_W  = 8,
  parameter int DUR_W  = 8,
  parameter int RATE_W = 4,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [THR_W-1:0]  thr_q,
  output logic [DUR_W-1:0]  dur_q,
  output logic [RATE_W-1:0] rate_q,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= '0;
      dur_q  <= '0;
      rate_q <= '0;
      mode_q <= '0;
    end else if (we) begin
      unique case (cfg_sel_e'(sel))
        SEL_THR:  thr_q  <= wdata[THR_W-1:0];
        SEL_DUR:  dur_q  <= wdata[DUR_W-1:0];
        SEL_RATE: rate_q <= wdata[RATE_W-1:0];
        SEL_MODE: mode_q <= wdata[MODE_W-1:0];
        default: ;
      endcase
    end
  end

  a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && sel == 2'd0) |=> (thr_q == $past(wdata[THR_W-1:0])));
endmodule

// File: rtl/act_detect.sv
module act_detect #(
  parameter int AXES     = 3,
  parameter int SAMPLE_W = 16,
  parameter int THR_W    = 8
) (
  input  logic [AXES*SAMPLE_W-1:0] samples,
  input  logic [THR_W-1:0]         thr,
  output logic                     above
);
  localparam int PAD_W = SAMPLE_W - THR_W;

  logic [SAMPLE_W-1:0] thr_ext;
  logic [AXES-1:0]     axis_hit;

  assign thr_ext = {{PAD_W{1'b0}}, thr};

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [SAMPLE_W-1:0] raw;
    logic [SAMPLE_W-1:0] mag;
    assign raw = samples[a*SAMPLE_W +: SAMPLE_W];
    assign mag = raw[SAMPLE_W-1] ? (~raw + SAMPLE_W'(1)) : raw;
    assign axis_hit[a] = (mag > thr_ext);
  end

  assign above = |axis_hit;
endmodule

// File: rtl/act_timer.sv
module act_timer #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             valid,
  input  logic             above,
  input  logic [DUR_W-1:0] dur,
  output logic             sleep_q,
  output logic             wake_q
);
  localparam int CNT_W = DUR_W + 3;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = {dur, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
      cnt     <= '0;
    end else begin
      wake_q <= 1'b0;
      if (!enable) begin
        sleep_q <= 1'b0;
        cnt     <= '0;
      end else if (valid) begin
        if (sleep_q) begin
          if (above) begin
            sleep_q <= 1'b0;
            wake_q  <= 1'b1;
            cnt     <= '0;
          end
        end else if (above) begin
          cnt <= '0;
        end else if (cnt >= last_idx) begin
          sleep_q <= 1'b1;
          cnt     <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  a_r2_off_stays_awake: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sleep_q && !wake_q));
  a_r5_motion_restarts: assert property (@(posedge clk) disable iff (rst)
    (enable && valid && above && !sleep_q) |=> (cnt == '0 && !sleep_q));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q);
  a_r6_pulse_on_fall: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> ($past(sleep_q) && !sleep_q));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (enable && !valid) |=> ($stable(cnt) && $stable(sleep_q)));
endmodule

// File: rtl/act_sleep_ctrl.sv
module act_sleep_ctrl #(
  parameter int                SAMPLE_W   = 16,
  parameter int                REG_W      = 8,
  parameter int                THR_W      = 8,
  parameter int                DUR_W      = 8,
  parameter int                RATE_W     = 4,
  parameter int                MODE_W     = 2,
  parameter logic [RATE_W-1:0] SLEEP_RATE = 4'h2,
  parameter logic [MODE_W-1:0] LP_MODE    = 2'b01
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_x,
  input  logic signed [SAMPLE_W-1:0] smp_y,
  input  logic signed [SAMPLE_W-1:0] smp_z,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [RATE_W-1:0]          eff_rate,
  output logic [MODE_W-1:0]          eff_mode,
  output logic                       asleep,
  output logic                       wake_evt
);
  localparam int AXES = 3;

  logic [THR_W-1:0]         thr_q;
  logic [DUR_W-1:0]         dur_q;
  logic [RATE_W-1:0]        urate_q;
  logic [MODE_W-1:0]        umode_q;
  logic [AXES*SAMPLE_W-1:0] packed_smp;
  logic                     any_above;
  logic                     feature_on;

  assign packed_smp = {smp_z, smp_y, smp_x};
  assign feature_on = (thr_q != '0);

  act_regs #(
    .REG_W(REG_W), .THR_W(THR_W), .DUR_W(DUR_W),
    .RATE_W(RATE_W), .MODE_W(MODE_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .thr_q(thr_q), .dur_q(dur_q), .rate_q(urate_q), .mode_q(umode_q)
  );

  act_detect #(
    .AXES(AXES), .SAMPLE_W(SAMPLE_W), .THR_W(THR_W)
  ) u_detect (
    .samples(packed_smp), .thr(thr_q), .above(any_above)
  );

  act_timer #(
    .DUR_W(DUR_W)
  ) u_timer (
    .clk(clk), .rst(rst), .enable(feature_on), .valid(smp_valid),
    .above(any_above), .dur(dur_q), .sleep_q(asleep), .wake_q(wake_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_rate <= '0;
      eff_mode <= '0;
    end else if (asleep) begin
      eff_rate <= SLEEP_RATE;
      eff_mode <= LP_MODE;
    end else begin
      eff_rate <= urate_q;
      eff_mode <= umode_q;
    end
  end

  a_r4_forced_low_power: assert property (@(posedge clk) disable iff (rst)
    asleep |=> (eff_rate == SLEEP_RATE && eff_mode == LP_MODE));
  a_r5_restore_user: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> (eff_rate == $past(urate_q) && eff_mode == $past(umode_q)));
  a_r2_disabled_passthrough: assert property (@(posedge clk) disable iff (rst)
    (thr_q == '0 && $past(thr_q) == '0) |=> (eff_rate == $past(urate_q)));
endmodule

// File: tb/sim_act_sleep_ctrl.sv
module sim_act_sleep_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] eff_rate;
  logic [1:0] eff_mode;
  logic asleep, wake_evt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // shadow model
  int m_thr = 0, m_dur = 0, m_rate = 0, m_mode = 0;
  int m_cnt = 0;
  bit m_sleep = 1'b0;
  bit m_wake = 1'b0;

  always #5 clk = ~clk;

  act_sleep_ctrl u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .eff_rate(eff_rate), .eff_mode(eff_mode),
    .asleep(asleep), .wake_evt(wake_evt)
  );

  function automatic int mag(input logic signed [15:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  function automatic int exp_rate();
    return m_sleep ? 2 : m_rate;
  endfunction

  function automatic int exp_mode();
    return m_sleep ? 1 : m_mode;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(input string req);
    chk(req, int'(asleep), int'(m_sleep));
    chk(req, int'(wake_evt), int'(m_wake));
  endtask

  task automatic check_eff(input string req);
    chk(req, int'(eff_rate), exp_rate());
    chk(req, int'(eff_mode), exp_mode());
    chk(req, int'(wake_evt), 0);
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: m_thr = data;
      1: m_dur = data;
      2: m_rate = data & 15;
      default: m_mode = data & 3;
    endcase
    @(negedge clk);
    if (m_thr == 0) begin m_sleep = 1'b0; m_cnt = 0; end
    m_wake = 1'b0;
    @(negedge clk);
  endtask

  task automatic smp(input string req, input logic signed [15:0] x,
                     input logic signed [15:0] y, input logic signed [15:0] z);
    bit above;
    @(negedge clk);
    smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
    above = (mag(x) > m_thr) || (mag(y) > m_thr) || (mag(z) > m_thr);
    m_wake = 1'b0;
    if (m_thr != 0) begin
      if (m_sleep) begin
        if (above) begin m_sleep = 1'b0; m_wake = 1'b1; m_cnt = 0; end
      end else if (above) m_cnt = 0;
      else if (m_cnt >= 8 * m_dur) begin m_sleep = 1'b1; m_cnt = 0; end
      else m_cnt++;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    check_out(req);
    m_wake = 1'b0;
    @(negedge clk);
    check_eff(req);
  endtask

  task automatic quiet(input string req, input int n, input int lvl);
    for (int i = 0; i < n; i++) begin
      logic signed [15:0] v;
      v = (i % 2 == 0) ? 16'(lvl) : -16'(lvl);
      smp(req, v, 16'(0), -v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0a17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(asleep), 0);
    chk("R1", int'(wake_evt), 0);
    chk("R1", int'(eff_rate), 0);
    chk("R1", int'(eff_mode), 0);

    // R2 threshold zero: long quiet stream never sleeps
    wr(2, 9);
    chk("R2", int'(eff_rate), 9);
    quiet("R2", 30, 0);

    // R9 register writes reach outputs while awake
    wr(0, 10); wr(1, 0); wr(2, 5); wr(3, 0);
    chk("R9", int'(eff_rate), 5);
    chk("R9", int'(eff_mode), 0);

    // R3 duration 0: one quiet sample sleeps; R4 override
    smp("R3", 16'(3), 16'(0), 16'(0));
    chk("R3", int'(asleep), 1);
    chk("R4", int'(eff_rate), 2);
    chk("R4", int'(eff_mode), 1);

    // R5/R6 wake on motion
    smp("R6", 16'(11), 16'(0), 16'(0));
    chk("R5", int'(eff_rate), 5);

    // R3/R8 duration 2: 16 quiet at exactly +/-threshold stay awake, 17th sleeps
    wr(1, 2);
    quiet("R8", 16, 10);
    chk("R3", int'(asleep), 0);
    quiet("R3", 1, 10);
    chk("R3", int'(asleep), 1);

    // R9 user rate change while asleep does not wake
    wr(2, 7);
    chk("R9", int'(asleep), 1);
    chk("R9", int'(eff_rate), 2);
    smp("R5", 16'(0), -16'(11), 16'(0));
    chk("R5", int'(eff_rate), 7);

    // R5 motion mid-window restarts count; R8 most negative value
    quiet("R5", 10, 4);
    smp("R8", 16'(0), 16'(0), 16'h8000);
    quiet("R5", 16, 4);
    chk("R5", int'(asleep), 0);
    quiet("R5", 1, 4);
    chk("R5", int'(asleep), 1);

    // R7 cycles without strobe do not count
    smp("R7", 16'(50), 16'(0), 16'(0));
    quiet("R7", 16, 1);
    repeat (60) @(negedge clk);
    chk("R7", int'(asleep), 0);
    quiet("R7", 1, 1);
    chk("R7", int'(asleep), 1);

    // R2 threshold cleared while asleep: awake, no pulse
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'd0;
    @(negedge clk);
    cfg_we = 1'b0; m_thr = 0;
    chk("R2", int'(wake_evt), 0);
    @(negedge clk);
    chk("R2", int'(asleep), 0);
    chk("R2", int'(wake_evt), 0);
    m_sleep = 1'b0; m_cnt = 0;
    @(negedge clk);
    chk("R2", int'(eff_rate), 7);

    // R3 longest window: duration 255 -> 2041 samples
    wr(0, 200); wr(1, 255);
    quiet("R3", 2040, 200);
    chk("R3", int'(asleep), 0);
    quiet("R3", 1, 200);
    chk("R3", int'(asleep), 1);
    smp("R6", 16'(0), 16'(201), 16'(0));

    // constrained random mix
    wr(1, 1);
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 2) wr(0, int'($urandom_range(0, 40)));
      else if (r < 4) wr(1, int'($urandom_range(0, 3)));
      else if (r < 6) wr(2 + int'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
      else if (r < 8) repeat (int'($urandom_range(1, 5))) @(negedge clk);
      else begin
        int lim;
        lim = (r < 15) ? 32767 : m_thr;
        smp("R5", 16'(int'($urandom_range(0, lim)) * ((r % 2) ? 1 : -1)),
            16'(int'($urandom_range(0, m_thr))),
            16'(-int'($urandom_range(0, m_thr))));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule